// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block joins two eight-input priority controllers, a master and a slave, so that sixteen request lines share one interrupt line toward a processor. The slave's interrupt output is wired internally to master input 2. Master input 2 therefore carries all slave requests, and the external line on that position is not used. Requests are caught on their rising edge. Each controller tracks which inputs are pending and which are in service. A non-specific end-of-interrupt strobe clears the highest-priority in-service input of the chosen controller.

The processor answers an interrupt with two acknowledge strobes. On the first strobe the master commits its winning input. If that input is marked as having a slave, the master places the input number on a 3-bit identity bus. On the second strobe the data byte is produced as follows:
- When the winning master input has no slave, the master supplies the byte: its 5-bit base and then the input number.
- When it has a slave, the byte comes from the slave whose identity matches the bus. That slave then commits its own winner.

Identities, bases, masks and the slave map are static configuration inputs.

Top module: `cascade_irq_pair`

## Requirements
- R1: After reset, irq_o is 0, cas_o is 0 and data_o is 0.
- R2: A request is latched only on a low-to-high transition of its line. A line that stays high after its request has been served raises no new interrupt.
- R3: A masked input (mask bit 1) does not raise irq_o, and its latched request is kept. Clearing the mask bit then raises irq_o.
- R4: Priority among the sixteen lines runs from highest to lowest: irq_i[0], irq_i[1], irq_i[8] to irq_i[15], then irq_i[3] to irq_i[7]. irq_i[2] has no effect.
- R5: When the winning master input n has no slave (map bit n is 0), cas_o is 0 after the first acknowledge. data_o is {m_base, n[2:0]} after the second acknowledge.
- R6: When the winning master input is 2 and map bit 2 is 1, cas_o is 3'd2 after the first acknowledge. If s_id is 2, data_o is {s_base, k[2:0]} after the second acknowledge, where k is the slave input that wins (line irq_i[8+k]).
- R7: When cas_o does not match s_id at the second acknowledge, data_o becomes 8'h00.
- R8: With map bit 2 cleared, a slave request is served as ordinary master input 2: data_o is {m_base, 3'd2} and cas_o is 0.
- R9: While an input is in service in a controller, inputs of equal or lower priority in that controller do not raise irq_o. Inputs of higher priority do.
- R10: The master runs in special fully nested mode. A higher-priority slave request raises irq_o while a slave interrupt is still in service.
- R11: An end-of-interrupt strobe clears only the highest-priority in-service input of its controller.
- R12: Acknowledge strobes alternate between first and second. data_o changes only on a second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines: [7:0] master, [15:8] slave |
| m_mask | input | 8 | Master input masks |
| s_mask | input | 8 | Slave input masks |
| m_base | input | 5 | Master vector high bits |
| s_base | input | 5 | Slave vector high bits |
| m_slave_map | input | 8 | Master inputs that have a slave |
| s_id | input | 3 | Slave identity |
| ack_i | input | 1 | Acknowledge strobe, one per cycle high |
| eoi_m_i | input | 1 | Master end-of-interrupt strobe |
| eoi_s_i | input | 1 | Slave end-of-interrupt strobe |
| irq_o | output | 1 | Interrupt to processor |
| cas_o | output | 3 | Slave identity bus |
| data_o | output | 8 | Vector byte |

## Verification
The assertions assume that acknowledges come only while irq_o is high and always in pairs. They also assume that an end-of-interrupt strobe never shares a cycle with an acknowledge, and that the configuration inputs hold steady across a pair. The stimulus meets these assumptions:
- It drives an acknowledge pair only after seeing irq_o high.
- It spaces strobes apart by idle cycles.
- It changes the configuration only while the block is idle or across a reset.

The random rounds raise arbitrary sets of lines and then serve them one at a time.

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int N = 8,
  parameter bit SELF_NEST = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic [N-1:0]         mask,
  input  logic                 take,
  input  logic                 eoi,
  output logic                 irq,
  output logic [$clog2(N)-1:0] win
);
  localparam int W = $clog2(N);

  logic [N-1:0] req_q, irr, isr, pend, eoi_b;
  logic [W-1:0] iidx;
  logic         ivalid;

  assign pend = irr & ~mask;

  always_comb begin
    win = '0;
    iidx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) win = W'(i);
      if (isr[i]) iidx = W'(i);
    end
  end

  assign ivalid = |isr;
  assign eoi_b  = (eoi && ivalid) ? (N'(1) << iidx) : '0;
  assign irq    = (|pend) && (!ivalid || (win < iidx) || (SELF_NEST && win == iidx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      irr   <= '0;
      isr   <= '0;
    end else begin
      req_q <= req;
      irr   <= (irr & ~(take ? (N'(1) << win) : '0)) | (req & ~req_q);
      isr   <= (isr & ~eoi_b) | (take ? (N'(1) << win) : '0);
    end
  end

  assert_take_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> isr[$past(win)]);
  assert_eoi_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !take && ivalid) |=> !isr[$past(iidx)]);
endmodule

// File: rtl/cascade_irq_pair.sv
module cascade_irq_pair #(
  parameter int SLAVE_IN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic [7:0]  m_mask,
  input  logic [7:0]  s_mask,
  input  logic [4:0]  m_base,
  input  logic [4:0]  s_base,
  input  logic [7:0]  m_slave_map,
  input  logic [2:0]  s_id,
  input  logic        ack_i,
  input  logic        eoi_m_i,
  input  logic        eoi_s_i,
  output logic        irq_o,
  output logic [2:0]  cas_o,
  output logic [7:0]  data_o
);
  logic [7:0] m_req;
  logic [2:0] mw, sw, mw_q, cas_q;
  logic       s_irq, phase, csc_q, first, second, hit;
  logic [7:0] data_q;

  assign m_req  = (irq_i[7:0] & ~(8'(1) << SLAVE_IN)) | ({7'b0, s_irq} << SLAVE_IN);
  assign first  = ack_i & ~phase;
  assign second = ack_i & phase;
  assign hit    = csc_q && (s_id == cas_q);

  irq_prio_core #(.N(8), .SELF_NEST(1'b1)) u_master (
    .clk(clk), .rst_n(rst_n), .req(m_req), .mask(m_mask),
    .take(first), .eoi(eoi_m_i), .irq(irq_o), .win(mw));

  irq_prio_core #(.N(8), .SELF_NEST(1'b0)) u_slave (
    .clk(clk), .rst_n(rst_n), .req(irq_i[15:8]), .mask(s_mask),
    .take(second & hit), .eoi(eoi_s_i), .irq(s_irq), .win(sw));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      csc_q  <= 1'b0;
      cas_q  <= '0;
      mw_q   <= '0;
      data_q <= '0;
    end else begin
      phase <= phase ^ ack_i;
      if (first) begin
        mw_q  <= mw;
        csc_q <= m_slave_map[mw];
        cas_q <= m_slave_map[mw] ? mw : 3'd0;
      end
      if (second)
        data_q <= csc_q ? (hit ? {s_base, sw} : 8'h00) : {m_base, mw_q};
    end
  end

  assign cas_o  = cas_q;
  assign data_o = data_q;

  assert_plain_cas_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (first && !m_slave_map[mw]) |=> cas_o == 3'd0);
  assert_slave_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (second && hit) |=> data_o[7:3] == $past(s_base));
  assert_mismatch_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (second && csc_q && s_id != cas_q) |=> data_o == 8'h00);
  assert_pair_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> phase);
  assert_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !second |=> $stable(data_o));
endmodule

// File: tb/test_cascade_irq_pair.sv
module test_cascade_irq_pair;
  localparam time TCK = 10ns;
  localparam logic [4:0] MB = 5'b00001;
  localparam logic [4:0] SB = 5'b01110;

  logic clk = 0, rst_n = 0, ack_i = 0, eoi_m_i = 0, eoi_s_i = 0;
  logic [15:0] irq_i = 0;
  logic [7:0] m_mask = 0, s_mask = 0, m_slave_map = 8'h04;
  logic [4:0] m_base = MB, s_base = SB;
  logic [2:0] s_id = 3'd2;
  logic irq_o;
  logic [2:0] cas_o;
  logic [7:0] data_o;
  int total = 0, bad = 0;
  logic [2:0] cas_seen;
  logic [7:0] data_mid;

  cascade_irq_pair i_cascade_irq_pair (.*);

  always #(TCK/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rank(int i);
    if (i < 2) return i;
    if (i >= 8) return i - 6;
    return i + 7;
  endfunction

  function automatic int pick(logic [15:0] s);
    int best = -1;
    for (int i = 0; i < 16; i++)
      if (s[i] && i != 2 && (best < 0 || rank(i) < rank(best))) best = i;
    return best;
  endfunction

  function automatic logic [7:0] vec(int i);
    return (i >= 8) ? {SB, 3'(i - 8)} : {MB, 3'(i)};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pair();
    @(negedge clk) ack_i = 1;
    @(negedge clk) begin cas_seen = cas_o; data_mid = data_o; end
    @(negedge clk) ack_i = 0;
  endtask

  task automatic eoi(bit slave);
    @(negedge clk) begin eoi_s_i = slave; eoi_m_i = !slave; end
    @(negedge clk) begin eoi_s_i = 0; eoi_m_i = 0; end
  endtask

  task automatic do_reset();
    irq_i = 0; rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rem;
    logic [7:0] prev;
    int w;
    void'($urandom(32'd1234));
    idle(3);
    chk("R1 irq", irq_o, 0);
    chk("R1 cas", cas_o, 0);
    chk("R1 data", data_o, 0);
    rst_n = 1;
    idle(2);

    // R4: irq_i[2] has no effect
    irq_i[2] = 1; idle(4);
    chk("R4 line2 ignored", irq_o, 0);
    irq_i[2] = 0; idle(2);

    // R3 mask
    m_mask = 8'h10; irq_i[4] = 1; idle(4);
    chk("R3 masked", irq_o, 0);
    m_mask = 0; idle(2);
    chk("R3 unmask", irq_o, 1);
    prev = data_o;
    ack_pair();
    chk("R12 data stable after first", data_mid, prev);
    chk("R5 vec", data_o, vec(4));
    chk("R5 cas", cas_seen, 0);
    eoi(0); irq_i[4] = 0; idle(2);

    // R2 held high
    irq_i[1] = 1; idle(4);
    ack_pair();
    chk("R2 vec", data_o, vec(1));
    eoi(0); idle(4);
    chk("R2 held line no repeat", irq_o, 0);
    irq_i[1] = 0; idle(2);

    // R9 / R11
    irq_i[5] = 1; idle(4);
    ack_pair();
    chk("R9 vec5", data_o, vec(5));
    irq_i[6] = 1; idle(4);
    chk("R9 lower blocked", irq_o, 0);
    irq_i[3] = 1; idle(4);
    chk("R9 higher passes", irq_o, 1);
    ack_pair();
    chk("R9 vec3", data_o, vec(3));
    eoi(0); idle(3);
    chk("R11 only 3 cleared", irq_o, 0);
    eoi(0); idle(3);
    chk("R11 5 cleared", irq_o, 1);
    ack_pair();
    chk("R11 vec6", data_o, vec(6));
    eoi(0); irq_i = 0; idle(3);

    // R10 / R6 nested slave
    irq_i[12] = 1; idle(5);
    ack_pair();
    chk("R6 cas", cas_seen, 3'd2);
    chk("R6 vec12", data_o, vec(12));
    irq_i[9] = 1; idle(5);
    chk("R10 nested slave raises", irq_o, 1);
    ack_pair();
    chk("R10 vec9", data_o, vec(9));
    eoi(1); eoi(1); eoi(0); idle(4);
    chk("R10 all done", irq_o, 0);
    irq_i = 0; idle(3);

    // random rounds: R4
    for (int r = 0; r < 40; r++) begin
      rem = 16'($urandom) & 16'hFFFB;
      if (rem == 0) rem = 16'h0100;
      irq_i = rem;
      while (rem != 0) begin
        idle(5);
        chk("R4 irq pending", irq_o, 1);
        ack_pair();
        w = pick(rem);
        chk("R4 vector", data_o, vec(w));
        chk("R4 cas", cas_seen, (w >= 8) ? 3'd2 : 3'd0);
        if (w >= 8) eoi(1);
        eoi(0);
        rem[w] = 1'b0;
      end
      idle(5);
      chk("R4 drained", irq_o, 0);
      irq_i = 0; idle(3);
    end

    // R8 map cleared
    m_slave_map = 0; do_reset();
    irq_i[10] = 1; idle(5);
    ack_pair();
    chk("R8 vec", data_o, {MB, 3'd2});
    chk("R8 cas", cas_seen, 0);
    m_slave_map = 8'h04; do_reset();

    // R7 id mismatch
    s_id = 3'd3; do_reset();
    irq_i[8] = 1; idle(5);
    ack_pair();
    chk("R7 cas", cas_seen, 3'd2);
    chk("R7 data", data_o, 8'h00);
    s_id = 3'd2; do_reset();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule